// File: doc/BRIEF.md
# Three-Colour Linear CCD Drive Sequencer

This block turns one system clock into the full set of drive waveforms for a three-colour linear CCD. It produces complementary two-phase shift clocks, copies of them for the last shift stage, a reset-gate pulse, a clamp pulse and one transfer-gate pulse shared by the three colour rows. Each line opens with a guarded transfer-gate interval. A fixed number of pixel periods follows, and each period carries one reset pulse. Every pixel is tagged as dark reference, active or dummy, so that the downstream capture logic knows which samples to keep.

All timing values are given in system-clock ticks: transfer-gate width, guard time, pixel period and the idle gap between lines. The sequencer captures these values, and the clamp style, at the moment a line is launched. It runs lines back to back while the run input stays high. If the timing values are out of range, the block stays idle and raises an error flag. With the default parameters at 200 MHz, the minimum limits are 5 µs for the gate, 900 ns for the guard and 100 ns for the pixel period, so the pixel rate is at most 10 MHz.

Top module: `ccd_tgen`

## Requirements
- R1: Reset is synchronous and active high. After reset the outputs are phase 1 high, phase 2 low, gate low, reset-gate low, clamp low, strobe low, tag 0 and error low. No line starts while `run_i` is low.
- R2: A line opens with a pre-guard of `cfg_guard_i` ticks in which the reset-gate output is high and the gate is low. The gate is then high for exactly `cfg_tg_width_i` ticks, and `line_start_o` is high only on the first gate-high cycle.
- R3: The shift clocks hold phase 1 high from the start of the pre-guard to the end of the post-guard of `cfg_guard_i` ticks after the gate falls. The first phase-1 fall comes `cfg_guard_i + floor(P/2)` ticks after the gate falls.
- R4: Phase 2 is always the inverse of phase 1, and the last-stage clocks equal the shift clocks. Within each pixel period of P ticks, phase 1 is high for the first floor(P/2) ticks.
- R5: Each line has exactly N_DARK+N_ACTIVE+N_DUM_A+N_DUM_B pixel periods of P = `cfg_pix_period_i` ticks. The reset-gate output is high for the first floor(P/4) ticks of each period.
- R6: `pix_class_o` uses 0 for no pixel, 1 for dummy, 2 for dark reference and 3 for active. Pixels come in the order: N_DARK dark, then N_ACTIVE active, then N_DUM_A+N_DUM_B dummy. The tag is 0 outside pixel periods.
- R7: In bit-clamp mode (`line_clamp_i`=0 at launch) the clamp is high through the pre-guard, the gate and the post-guard. Within a pixel it is high only for ticks floor(P/4) up to 2·floor(P/4)-1, right after the reset pulse. It is low between lines.
- R8: In line-clamp mode (`line_clamp_i`=1 at launch) the clamp output is the inverse of the gate output for the whole line.
- R9: The clamp mode is captured only when a line is launched. A change of `line_clamp_i` during a line affects the next line only.
- R10: A new line is launched `cfg_gap_i` ticks after the last pixel period ends, and only if `run_i` is high. Consecutive line starts are therefore 2·guard + gate width + pixels·P + gap ticks apart.
- R11: The configuration is invalid when the gate width is below TG_MIN, the guard is below GUARD_MIN or the pixel period is below PIX_MIN. `cfg_err_o` then rises one cycle later, any line in progress is abandoned and all outputs go idle. A value exactly at its minimum is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Allows lines to be launched |
| line_clamp_i | input | 1 | Clamp style for the next line: 0 bit clamp, 1 line clamp |
| cfg_tg_width_i | input | CFG_W | Gate high width in ticks |
| cfg_guard_i | input | CFG_W | Guard before and after the gate in ticks |
| cfg_pix_period_i | input | CFG_W | Pixel period in ticks |
| cfg_gap_i | input | CFG_W | Idle ticks between lines |
| phi1_o | output | 1 | Shift clock phase 1 |
| phi2_o | output | 1 | Shift clock phase 2 |
| phi1_last_o | output | 1 | Last-stage shift clock phase 1 |
| phi2_last_o | output | 1 | Last-stage shift clock phase 2 |
| rst_gate_o | output | 1 | Reset-gate pulse |
| clamp_o | output | 1 | Clamp pulse |
| tg_o | output | 1 | Transfer-gate pulse shared by all colours |
| line_start_o | output | 1 | One-cycle strobe on the first gate-high cycle |
| pix_class_o | output | 2 | Pixel tag (0 none, 1 dummy, 2 dark, 3 active) |
| cfg_err_o | output | 1 | Invalid configuration flag |

## Verification
The assertions check several relations on every cycle. The shift clocks stay frozen and the reset gate stays high while the gate is high, and in bit-clamp mode the clamp is also high then. The strobe coincides with each gate rise, and no pixel is tagged during the gate. The error flag forces idle outputs, the captured mode holds steady during the gate, and the pixel counters stay in range. Other behaviour shows only in whole-line scenarios run by the bench: exact guard and gate lengths, the pixel count and class order, the reset and clamp pulse widths, the line-to-line spacing, the capture of the mode at launch, abandoning a line on a bad configuration, and accepting values exactly at their limits.

// File: rtl/ccd_tgen_pkg.sv
package ccd_tgen_pkg;
  typedef enum logic [1:0] {
    PCLS_NONE   = 2'd0,
    PCLS_DUMMY  = 2'd1,
    PCLS_DARK   = 2'd2,
    PCLS_ACTIVE = 2'd3
  } pix_class_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_GATE, PH_POST, PH_PIX, PH_GAP
  } phase_e;
endpackage

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
  parameter int CFG_W     = 16,
  parameter int TG_MIN    = 1000,
  parameter int GUARD_MIN = 180,
  parameter int PIX_MIN   = 20
) (
  input  logic [CFG_W-1:0] tg_width,
  input  logic [CFG_W-1:0] guard,
  input  logic [CFG_W-1:0] period,
  output logic             bad
);
  localparam logic [CFG_W-1:0] TG_LIM  = CFG_W'(TG_MIN);
  localparam logic [CFG_W-1:0] GD_LIM  = CFG_W'(GUARD_MIN);
  localparam logic [CFG_W-1:0] PIX_LIM = CFG_W'(PIX_MIN);

  always_comb bad = (tg_width < TG_LIM) || (guard < GD_LIM) || (period < PIX_LIM);
endmodule

// File: rtl/ccd_pix_map.sv
module ccd_pix_map
  import ccd_tgen_pkg::*;
#(
  parameter int N_DARK   = 49,
  parameter int N_ACTIVE = 10680,
  parameter int PW       = 14
) (
  input  logic          in_pixel,
  input  logic [PW-1:0] idx,
  output pix_class_e    cls
);
  localparam logic [PW-1:0] END_DARK   = PW'(N_DARK);
  localparam logic [PW-1:0] END_ACTIVE = PW'(N_DARK + N_ACTIVE);

  always_comb begin
    if (!in_pixel)              cls = PCLS_NONE;
    else if (idx < END_DARK)    cls = PCLS_DARK;
    else if (idx < END_ACTIVE)  cls = PCLS_ACTIVE;
    else                        cls = PCLS_DUMMY;
  end
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_tgen_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int N_PIX = 10734,
  parameter int PW    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bad,
  input  logic             mode_in,
  input  logic [CFG_W-1:0] tg_width,
  input  logic [CFG_W-1:0] guard,
  input  logic [CFG_W-1:0] period,
  input  logic [CFG_W-1:0] gap,
  output phase_e           ph,
  output logic [CFG_W-1:0] tick,
  output logic [CFG_W-1:0] per_q,
  output logic [PW-1:0]    idx,
  output logic             gate_first,
  output logic             mode_q
);
  localparam logic [CFG_W-1:0] ONE      = CFG_W'(1);
  localparam logic [PW-1:0]    PONE     = PW'(1);
  localparam logic [PW-1:0]    LAST_IDX = PW'(N_PIX - 1);

  logic [CFG_W-1:0] cnt, cnt_n, tick_n, tgw_q, gd_q, gap_q;
  logic [PW-1:0]    idx_n;
  phase_e           ph_n;
  logic             pix_end, line_end, gap_end, launch;

  always_comb begin
    pix_end  = (ph == PH_PIX) && (tick == per_q - ONE);
    line_end = pix_end && (idx == LAST_IDX);
    gap_end  = (ph == PH_GAP) && (cnt + ONE >= gap_q);
    launch   = run && !bad &&
               ((ph == PH_IDLE) || gap_end || (line_end && gap_q == '0));
  end

  always_comb begin
    ph_n = ph; cnt_n = cnt + ONE; tick_n = tick; idx_n = idx;
    case (ph)
      PH_IDLE: cnt_n = '0;
      PH_PRE:  if (cnt == gd_q - ONE)  begin ph_n = PH_GATE; cnt_n = '0; end
      PH_GATE: if (cnt == tgw_q - ONE) begin ph_n = PH_POST; cnt_n = '0; end
      PH_POST: if (cnt == gd_q - ONE) begin
                 ph_n = PH_PIX; cnt_n = '0; tick_n = '0; idx_n = '0;
               end
      PH_PIX: begin
        cnt_n  = '0;
        tick_n = tick + ONE;
        if (pix_end) begin
          tick_n = '0;
          idx_n  = idx + PONE;
          if (line_end) begin
            idx_n = '0;
            ph_n  = (gap_q == '0) ? PH_IDLE : PH_GAP;
          end
        end
      end
      PH_GAP:  if (gap_end) begin ph_n = PH_IDLE; cnt_n = '0; end
      default: ph_n = PH_IDLE;
    endcase
    if (launch) begin ph_n = PH_PRE; cnt_n = '0; end
    if (bad) begin ph_n = PH_IDLE; cnt_n = '0; tick_n = '0; idx_n = '0; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; tick <= '0; idx <= '0;
    end else begin
      ph <= ph_n; cnt <= cnt_n; tick <= tick_n; idx <= idx_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0; tgw_q <= '0; gd_q <= '0; per_q <= '0; gap_q <= '0;
    end else if (launch) begin
      mode_q <= mode_in; tgw_q <= tg_width; gd_q <= guard;
      per_q  <= period;  gap_q <= gap;
    end
  end

  always_comb gate_first = (ph == PH_GATE) && (cnt == '0);

  AST_IDX_RANGE:  assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PIX) |-> (idx <= LAST_IDX));                       // R6
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PIX) |-> (tick < per_q));                          // R5
  AST_MODE_HELD:  assert property (@(posedge clk) disable iff (rst)
    (ph == PH_GATE) |=> $stable(mode_q));                        // R9
endmodule

// File: rtl/ccd_tgen.sv
module ccd_tgen
  import ccd_tgen_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int TG_MIN    = 1000,
  parameter int GUARD_MIN = 180,
  parameter int PIX_MIN   = 20,
  parameter int N_DARK    = 49,
  parameter int N_ACTIVE  = 10680,
  parameter int N_DUM_A   = 2,
  parameter int N_DUM_B   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             line_clamp_i,
  input  logic [CFG_W-1:0] cfg_tg_width_i,
  input  logic [CFG_W-1:0] cfg_guard_i,
  input  logic [CFG_W-1:0] cfg_pix_period_i,
  input  logic [CFG_W-1:0] cfg_gap_i,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             phi1_last_o,
  output logic             phi2_last_o,
  output logic             rst_gate_o,
  output logic             clamp_o,
  output logic             tg_o,
  output logic             line_start_o,
  output logic [1:0]       pix_class_o,
  output logic             cfg_err_o
);
  localparam int N_PIX = N_DARK + N_ACTIVE + N_DUM_A + N_DUM_B;
  localparam int PW    = $clog2(N_PIX);

  logic             bad, gate_first, mode_q;
  phase_e           ph;
  logic [CFG_W-1:0] tick, per_q, half, quarter, quarter2;
  logic [PW-1:0]    idx;
  pix_class_e       cls;
  logic             d_phi1, d_rs, d_bclamp, d_tg, guard_zone;

  ccd_cfg_check #(.CFG_W(CFG_W), .TG_MIN(TG_MIN), .GUARD_MIN(GUARD_MIN), .PIX_MIN(PIX_MIN))
    u_chk (.tg_width(cfg_tg_width_i), .guard(cfg_guard_i), .period(cfg_pix_period_i), .bad(bad));

  ccd_line_seq #(.CFG_W(CFG_W), .N_PIX(N_PIX), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .run(run_i), .bad(bad), .mode_in(line_clamp_i),
    .tg_width(cfg_tg_width_i), .guard(cfg_guard_i), .period(cfg_pix_period_i),
    .gap(cfg_gap_i), .ph(ph), .tick(tick), .per_q(per_q), .idx(idx),
    .gate_first(gate_first), .mode_q(mode_q));

  ccd_pix_map #(.N_DARK(N_DARK), .N_ACTIVE(N_ACTIVE), .PW(PW))
    u_map (.in_pixel(ph == PH_PIX), .idx(idx), .cls(cls));

  always_comb begin
    half       = per_q >> 1;
    quarter    = per_q >> 2;
    quarter2   = quarter << 1;
    guard_zone = (ph == PH_PRE) || (ph == PH_GATE) || (ph == PH_POST);
    d_tg       = (ph == PH_GATE);
    d_phi1     = (ph == PH_PIX) ? (tick < half) : 1'b1;
    d_rs       = guard_zone || ((ph == PH_PIX) && (tick < quarter));
    d_bclamp   = guard_zone ||
                 ((ph == PH_PIX) && (tick >= quarter) && (tick < quarter2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi1_o <= 1'b1; phi2_o <= 1'b0; phi1_last_o <= 1'b1; phi2_last_o <= 1'b0;
      rst_gate_o <= 1'b0; clamp_o <= 1'b0; tg_o <= 1'b0; line_start_o <= 1'b0;
      pix_class_o <= PCLS_NONE; cfg_err_o <= 1'b0;
    end else begin
      phi1_o       <= d_phi1;
      phi2_o       <= !d_phi1;
      phi1_last_o  <= d_phi1;
      phi2_last_o  <= !d_phi1;
      rst_gate_o   <= d_rs;
      clamp_o      <= mode_q ? !d_tg : d_bclamp;
      tg_o         <= d_tg;
      line_start_o <= gate_first;
      pix_class_o  <= cls;
      cfg_err_o    <= bad;
    end
  end

  AST_GATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (phi1_o && !phi2_o && phi1_last_o && !phi2_last_o));   // R3
  AST_GATE_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> rst_gate_o);                                           // R2
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(tg_o) |-> line_start_o);                                  // R2
  AST_STROBE_IN_GATE: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> tg_o);                                         // R2
  AST_GATE_NO_PIXEL: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (pix_class_o == PCLS_NONE));                           // R6
  AST_BIT_CLAMP_GATE: assert property (@(posedge clk) disable iff (rst)
    (tg_o && !mode_q) |-> clamp_o);                                 // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> (!tg_o && !rst_gate_o && pix_class_o == PCLS_NONE)); // R11
endmodule

// File: tb/ccd_tgen_bench.sv
`timescale 1ns/1ps
module ccd_tgen_bench;
  localparam int CFG_W = 16;
  localparam int ND = 49, NA = 16, NDA = 2, NDB = 3;
  localparam int TOT = ND + NA + NDA + NDB;

  typedef struct {
    int pre_len; int tg_len; int post_phi; int frozen_bad; int npix;
    int n_dark; int n_act; int n_dum; int order_bad; int per_min; int per_max;
    int rsw_min; int rsw_max; int clamp_rises; int clamp_tg_hi; int clamp_low_pix;
    int phi1_hi_pix; int span; int mis;
  } rec_t;

  logic clk = 1'b0;
  logic rst, run_i, line_clamp_i;
  logic [CFG_W-1:0] tgw, gd, per, gap;
  logic phi1, phi2, phi1l, phi2l, rsg, clamp, tg, ls, err;
  logic [1:0] cls;

  int total = 0, bad = 0;
  int n_begin = 0, tg_total = 0;
  int flush_req = 0, flush_ack = 0, disc_req = 0, disc_ack = 0;
  rec_t exp_q[$];

  always #2.5 clk = ~clk;

  ccd_tgen #(.CFG_W(CFG_W), .TG_MIN(8), .GUARD_MIN(4), .PIX_MIN(4),
             .N_DARK(ND), .N_ACTIVE(NA), .N_DUM_A(NDA), .N_DUM_B(NDB)) u_ccd_tgen (
    .clk(clk), .rst(rst), .run_i(run_i), .line_clamp_i(line_clamp_i),
    .cfg_tg_width_i(tgw), .cfg_guard_i(gd), .cfg_pix_period_i(per), .cfg_gap_i(gap),
    .phi1_o(phi1), .phi2_o(phi2), .phi1_last_o(phi1l), .phi2_last_o(phi2l),
    .rst_gate_o(rsg), .clamp_o(clamp), .tg_o(tg), .line_start_o(ls),
    .pix_class_o(cls), .cfg_err_o(err));

  task automatic cmp(string req, string what, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, expv);
    end
  endtask

  function automatic rec_t mk(bit lm, int w, int g, int p, int gp, bit nxt);
    rec_t r;
    int h = p / 2;
    int q = p / 4;
    r.pre_len = g; r.tg_len = w; r.post_phi = g + h; r.frozen_bad = 0;
    r.npix = TOT; r.n_dark = ND; r.n_act = NA; r.n_dum = NDA + NDB; r.order_bad = 0;
    r.per_min = p; r.per_max = p; r.rsw_min = q; r.rsw_max = q;
    r.clamp_rises   = lm ? 0 : TOT;
    r.clamp_tg_hi   = lm ? 0 : w;
    r.clamp_low_pix = lm ? 0 : TOT * (p - q);
    r.phi1_hi_pix = TOT * h;
    r.span = nxt ? (2 * g + w + TOT * p + gp) : 0;
    r.mis = 0;
    return r;
  endfunction

  function automatic rec_t blank();
    rec_t r;
    r = '{default: 0};
    r.per_min = 1000000; r.rsw_min = 1000000;
    return r;
  endfunction

  // scoreboard compare of one finished line
  task automatic close_line(rec_t g);
    rec_t e;
    if (exp_q.size() == 0) begin
      cmp("R10", "unexpected line", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    cmp("R2", "pre-guard length", g.pre_len, e.pre_len);
    cmp("R2", "gate width", g.tg_len, e.tg_len);
    cmp("R3", "gate fall to first phase-1 fall", g.post_phi, e.post_phi);
    cmp("R3", "shift clock moved in guard/gate", g.frozen_bad, e.frozen_bad);
    cmp("R5", "pixel count", g.npix, e.npix);
    cmp("R6", "dark pixels", g.n_dark, e.n_dark);
    cmp("R6", "active pixels", g.n_act, e.n_act);
    cmp("R6", "dummy pixels", g.n_dum, e.n_dum);
    cmp("R6", "class order", g.order_bad, e.order_bad);
    cmp("R5", "min pixel period", g.per_min, e.per_min);
    cmp("R5", "max pixel period", g.per_max, e.per_max);
    cmp("R5", "min reset width", g.rsw_min, e.rsw_min);
    cmp("R5", "max reset width", g.rsw_max, e.rsw_max);
    cmp("R7 R8 R9", "clamp rises in pixels", g.clamp_rises, e.clamp_rises);
    cmp("R7 R8 R9", "clamp high during gate", g.clamp_tg_hi, e.clamp_tg_hi);
    cmp("R7 R8 R9", "clamp low in pixels", g.clamp_low_pix, e.clamp_low_pix);
    cmp("R4", "phase-1 high in pixels", g.phi1_hi_pix, e.phi1_hi_pix);
    cmp("R10", "line spacing", g.span, e.span);
    cmp("R2 R4", "strobe/clock relation errors", g.mis, e.mis);
  endtask

  // monitor
  rec_t cur;
  bit open = 0, post_done = 0, in_pulse = 0;
  int mph = 0, cyc = 0, begin_at = 0, last_pix = 0, w = 0, rank = 0;
  logic p_rs = 0, p_clamp = 0, p_tg = 0;
  logic [1:0] p_cls = 0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (tg) tg_total++;
      if (disc_req != disc_ack) begin disc_ack++; open = 0; end
      if (flush_req != flush_ack) begin
        flush_ack++;
        if (open) begin cur.span = 0; close_line(cur); open = 0; end
      end
      if (rsg && !p_rs && cls == 2'd0 && !tg) begin
        if (open) begin cur.span = cyc - begin_at; close_line(cur); end
        cur = blank(); open = 1; mph = 1; begin_at = cyc; post_done = 0;
        in_pulse = 0; rank = 0; n_begin++;
      end
      if (open) begin
        if (ls != (tg && !p_tg) || phi1l != phi1 || phi2l != phi2 || phi2 == phi1) cur.mis++;
        if (mph == 1 && tg) mph = 2;
        if (mph == 2 && !tg) mph = 3;
        if (mph == 1) begin cur.pre_len++; if (!phi1) cur.frozen_bad++; end
        if (mph == 2) begin cur.tg_len++; if (!phi1) cur.frozen_bad++; end
        if (mph == 3 && !post_done) begin
          if (phi1) cur.post_phi++; else post_done = 1;
        end
        if (tg && clamp) cur.clamp_tg_hi++;
        if (in_pulse && !rsg) begin
          in_pulse = 0;
          if (w < cur.rsw_min) cur.rsw_min = w;
          if (w > cur.rsw_max) cur.rsw_max = w;
        end else if (in_pulse) w++;
        if (cls != 2'd0) begin
          if (p_cls == 2'd0 || (rsg && !p_rs)) begin
            cur.npix++;
            if (cur.npix > 1) begin
              if (cyc - last_pix < cur.per_min) cur.per_min = cyc - last_pix;
              if (cyc - last_pix > cur.per_max) cur.per_max = cyc - last_pix;
            end
            last_pix = cyc;
            case (cls)
              2'd2: begin cur.n_dark++; if (rank > 0) cur.order_bad++; rank = 0; end
              2'd3: begin cur.n_act++;  if (rank > 1) cur.order_bad++; rank = 1; end
              default: begin cur.n_dum++; rank = 2; end
            endcase
          end
          if (rsg && !p_rs) begin in_pulse = 1; w = 1; end
          if (!clamp) cur.clamp_low_pix++;
          if (clamp && !p_clamp) cur.clamp_rises++;
          if (phi1) cur.phi1_hi_pix++;
        end
      end
      p_rs = rsg; p_clamp = clamp; p_tg = tg; p_cls = cls;
    end
  end

  task automatic wait_begin(int k);
    while (n_begin < k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int nb, tt;
    rst = 1; run_i = 0; line_clamp_i = 0;
    tgw = 12; gd = 5; per = 8; gap = 7;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "phase 1 after reset", phi1, 1);
    cmp("R1", "phase 2 after reset", phi2, 0);
    cmp("R1", "gate after reset", tg, 0);
    cmp("R1", "reset gate / clamp after reset", {rsg, clamp}, 0);
    cmp("R1", "strobe/tag/error after reset", {ls, cls, err}, 0);
    repeat (40) @(negedge clk);
    cmp("R1", "no line while run low", n_begin + tg_total, 0);

    // bit clamp, two back-to-back lines with a gap
    exp_q.push_back(mk(0, 12, 5, 8, 7, 1));
    exp_q.push_back(mk(0, 12, 5, 8, 7, 0));
    run_i = 1;
    wait_begin(2);
    run_i = 0;
    repeat (650) @(negedge clk);
    flush_req++;
    repeat (2) @(negedge clk);

    // line clamp at minimum gate/guard, odd period, zero gap; mode flip mid-line (R9)
    line_clamp_i = 1; tgw = 8; gd = 4; per = 5; gap = 0;
    exp_q.push_back(mk(1, 8, 4, 5, 0, 1));
    exp_q.push_back(mk(0, 8, 4, 5, 0, 0));
    run_i = 1;
    wait_begin(3);
    while (cls == 2'd0) @(negedge clk);
    line_clamp_i = 0;
    wait_begin(4);
    run_i = 0;
    repeat (420) @(negedge clk);
    flush_req++;
    repeat (2) @(negedge clk);

    // minimum pixel period, bit clamp
    per = 4; gap = 3;
    exp_q.push_back(mk(0, 8, 4, 4, 3, 0));
    run_i = 1;
    wait_begin(5);
    run_i = 0;
    repeat (350) @(negedge clk);
    flush_req++;
    repeat (2) @(negedge clk);
    cmp("R10", "lines still expected", exp_q.size(), 0);

    // R11 invalid configurations
    tgw = 7;
    repeat (2) @(negedge clk);
    cmp("R11", "error flag for short gate", err, 1);
    run_i = 1; nb = n_begin; tt = tg_total;
    repeat (100) @(negedge clk);
    cmp("R11", "lines launched with bad config", n_begin - nb + tg_total - tt, 0);
    tgw = 8; per = 3;
    repeat (2) @(negedge clk);
    cmp("R11", "error flag for short period", err, 1);
    per = 4; gd = 3;
    repeat (2) @(negedge clk);
    cmp("R11", "error flag for short guard", err, 1);
    gd = 4;
    repeat (2) @(negedge clk);
    cmp("R11", "error flag at exact minimums", err, 0);
    while (!tg) @(negedge clk);
    per = 3;
    repeat (3) @(negedge clk);
    cmp("R11", "gate after abort", tg, 0);
    cmp("R11", "reset gate and tag after abort", {rsg, cls}, 0);
    cmp("R11", "error flag during abort", err, 1);
    disc_req++;
    run_i = 0; per = 4;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule